// File: doc/BRIEF.md
# Special Register Latency Scoreboard

This block keeps a hazard record for a bank of special-purpose registers. It stores two counts for each register. The first is a staged latency that execution units raise. The second is a live count of the cycles left before the register can be used.

At the end of each instruction a commit strobe copies every nonzero staged latency into the live count and clears the staged value. A cycle-advance input then lowers all live counts together, and a count never drops below zero. Issue logic looks up the registers an instruction group touches. The block keeps the largest live count it has seen as the number of cycles that group must stall. This covers special-register moves in both directions: reading a special register into a general register, and writing a general register into a special register.

The block also turns a general or floating register number into the matching non-excepting-flag register. Each class has two flag registers. A non-excepting divide raises the flag register of its destination. A clear operation waits on the flag register of its target, or on both flag registers of its class when it clears all of them.

Top module: `spr_latency_board`

## Requirements
- R1: A synchronous active-high reset sets every live count, every staged latency and the `stall` output to zero.
- R2: A top-up writes the staged latency of its register only when its cycle count is larger than the staged value already held, so a smaller later top-up has no effect.
- R3: A top-up or lookup whose index is negative (top bit of the index set) changes no state and adds no stall.
- R4: On `commit`, each register with a nonzero staged value has its live count loaded with that value, and the staged value is cleared. A top-up in the same cycle becomes the new staged value. A register with zero staged value keeps its live count.
- R5: On an advance of N cycles, a live count that is less than or equal to N becomes zero, and any other live count is reduced by N.
- R6: `stall` is registered. After each edge it equals the maximum of its previous value and the pre-edge live counts of every register looked up in that cycle. When `group_start` is set, the previous value is taken as zero.
- R7: For a register number, 32 to 63 selects flag register 0 of its class and 1 to 31 selects flag register 1. Number 0, numbers above 63 and negative numbers other than -1 select neither. Flag register indices default to 4 (general, 0), 5 (general, 1), 6 (floating, 0) and 7 (floating, 1).
- R8: A clear lookup with register number -1 waits on both flag registers of the class chosen by `clr_float`.
- R9: A non-excepting divide raises the staged latency of the flag register mapped from its destination to 18 cycles.
- R10: A top-up cycle count above 255 is stored as 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| topup_idx | input | IDX_W+1 | Signed register index for a latency top-up; negative means none |
| topup_cycles | input | TCY_W | Requested latency in cycles |
| div_valid | input | 1 | A non-excepting divide is issuing |
| div_dst | input | RN_W | Signed general register number of the divide destination |
| commit | input | 1 | End of instruction: move staged latencies into live counts |
| adv_cycles | input | 8 | Cycles elapsed; 0 means no advance |
| group_start | input | 1 | A new issue group starts; accumulated stall restarts from zero |
| lk0_idx | input | IDX_W+1 | Signed index for lookup port 0; negative means none |
| lk1_idx | input | IDX_W+1 | Signed index for lookup port 1; negative means none |
| clr_valid | input | 1 | A flag-clear operation is checking its flag registers |
| clr_float | input | 1 | Clear targets the floating class (1) or the general class (0) |
| clr_reg | input | RN_W | Signed target register number of the clear; -1 means all |
| stall | output | 8 | Accumulated stall count for the current issue group |

## Verification
The hardest case to reach is a register whose live count and staged value differ, and which is then hit by a commit, an advance and a new top-up in the same or adjacent cycles. Only lookups can reveal it, and only after a commit. The stimulus table stages a latency and tops up the same register in the commit cycle. It then advances while the register is being looked up and commits again with nothing staged, so that the load and the hold behaviour both appear on `stall`. A staged top-up that is followed by reset and then a commit shows that reset also cleared the staged store.

// File: rtl/spr_sb_pkg.sv
package spr_sb_pkg;
  localparam int CNT_W = 8;
  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t CNT_MAX = '1;
endpackage

// File: rtl/spr_flag_map.sv
// Maps a signed register number onto the two flag registers of its class.
module spr_flag_map #(
  parameter int RN_W = 8
) (
  input  logic signed [RN_W-1:0] rnum,
  input  logic                   all_ok,
  output logic                   sel0,
  output logic                   sel1
);
  localparam logic [RN_W-2:0] LO_MIN = (RN_W-1)'(1);
  localparam logic [RN_W-2:0] LO_MAX = (RN_W-1)'(31);
  localparam logic [RN_W-2:0] HI_MIN = (RN_W-1)'(32);
  localparam logic [RN_W-2:0] HI_MAX = (RN_W-1)'(63);

  logic            neg;
  logic [RN_W-2:0] mag;
  logic            want_all;
  logic            in_hi;
  logic            in_lo;

  always_comb begin
    neg      = rnum[RN_W-1];
    mag      = rnum[RN_W-2:0];
    want_all = all_ok && (rnum == '1);
    in_hi    = !neg && (mag >= HI_MIN) && (mag <= HI_MAX);
    in_lo    = !neg && (mag >= LO_MIN) && (mag <= LO_MAX);
    sel0     = want_all || in_hi;
    sel1     = want_all || in_lo;
  end
endmodule

// File: rtl/spr_track_cell.sv
// Staged latency plus live busy count for one register.
module spr_track_cell
  import spr_sb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic commit,
  input  cnt_t adv,
  input  logic hit_a,
  input  cnt_t val_a,
  input  logic hit_b,
  input  cnt_t val_b,
  output cnt_t busy
);
  cnt_t pend_q, busy_q;
  cnt_t p0, p1, p2, b_next;

  always_comb begin
    p0 = commit ? '0 : pend_q;
    p1 = (hit_a && val_a > p0) ? val_a : p0;
    p2 = (hit_b && val_b > p1) ? val_b : p1;
    if (commit && pend_q != '0) b_next = pend_q;
    else if (busy_q <= adv)     b_next = '0;
    else                        b_next = busy_q - adv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      busy_q <= '0;
    end else begin
      pend_q <= p2;
      busy_q <= b_next;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/spr_stall_merge.sv
// Running maximum over a set of optional candidate counts.
module spr_stall_merge
  import spr_sb_pkg::*;
#(
  parameter int N = 4
) (
  input  cnt_t         base,
  input  logic [N-1:0] vld,
  input  cnt_t [N-1:0] val,
  output cnt_t         result
);
  cnt_t chain [N+1];
  assign chain[0] = base;
  for (genvar g = 0; g < N; g++) begin : g_stage
    assign chain[g+1] = (vld[g] && val[g] > chain[g]) ? val[g] : chain[g];
  end
  assign result = chain[N];
endmodule

// File: rtl/spr_latency_board.sv
module spr_latency_board
  import spr_sb_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int TCY_W   = 16,
  parameter int RN_W    = 8,
  parameter int DIV_LAT = 18,
  parameter int FLAG_G0 = 4,
  parameter int FLAG_G1 = 5,
  parameter int FLAG_F0 = 6,
  parameter int FLAG_F1 = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [IDX_W:0]   topup_idx,
  input  logic [TCY_W-1:0]        topup_cycles,
  input  logic                    div_valid,
  input  logic signed [RN_W-1:0]  div_dst,
  input  logic                    commit,
  input  logic [7:0]              adv_cycles,
  input  logic                    group_start,
  input  logic signed [IDX_W:0]   lk0_idx,
  input  logic signed [IDX_W:0]   lk1_idx,
  input  logic                    clr_valid,
  input  logic                    clr_float,
  input  logic signed [RN_W-1:0]  clr_reg,
  output logic [7:0]              stall
);
  localparam int NREG = 1 << IDX_W;
  localparam int NLK  = 4;
  localparam logic [IDX_W-1:0] IG0 = IDX_W'(FLAG_G0);
  localparam logic [IDX_W-1:0] IG1 = IDX_W'(FLAG_G1);
  localparam logic [IDX_W-1:0] IF0 = IDX_W'(FLAG_F0);
  localparam logic [IDX_W-1:0] IF1 = IDX_W'(FLAG_F1);
  localparam logic [TCY_W-1:0] SAT_LIM = TCY_W'(CNT_MAX);

  // Top-up sources: generic port (a) and divide flag (b)
  logic             up_a_ok;
  logic [IDX_W-1:0] up_a_idx;
  cnt_t             up_a_val;
  logic             div_s0, div_s1;
  logic             up_b_ok;
  logic [IDX_W-1:0] up_b_idx;

  assign up_a_ok  = !topup_idx[IDX_W];
  assign up_a_idx = topup_idx[IDX_W-1:0];
  assign up_a_val = (topup_cycles > SAT_LIM) ? CNT_MAX : topup_cycles[CNT_W-1:0];

  spr_flag_map #(.RN_W(RN_W)) u_div_map (
    .rnum(div_dst), .all_ok(1'b0), .sel0(div_s0), .sel1(div_s1)
  );
  assign up_b_ok  = div_valid && (div_s0 || div_s1);
  assign up_b_idx = div_s0 ? IG0 : IG1;

  // Register cells
  cnt_t busy_all [NREG];
  for (genvar r = 0; r < NREG; r++) begin : g_cell
    spr_track_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .commit(commit),
      .adv   (adv_cycles),
      .hit_a (up_a_ok && up_a_idx == IDX_W'(r)),
      .val_a (up_a_val),
      .hit_b (up_b_ok && up_b_idx == IDX_W'(r)),
      .val_b (cnt_t'(DIV_LAT)),
      .busy  (busy_all[r])
    );
  end

  // Lookups: two ports plus the two flag registers of a clear
  logic clr_s0, clr_s1;
  spr_flag_map #(.RN_W(RN_W)) u_clr_map (
    .rnum(clr_reg), .all_ok(1'b1), .sel0(clr_s0), .sel1(clr_s1)
  );

  logic [NLK-1:0] lk_vld;
  cnt_t [NLK-1:0] lk_val;
  cnt_t           stall_q, stall_base, stall_d;

  always_comb begin
    lk_vld[0] = !lk0_idx[IDX_W];
    lk_val[0] = busy_all[lk0_idx[IDX_W-1:0]];
    lk_vld[1] = !lk1_idx[IDX_W];
    lk_val[1] = busy_all[lk1_idx[IDX_W-1:0]];
    lk_vld[2] = clr_valid && clr_s0;
    lk_val[2] = busy_all[clr_float ? IF0 : IG0];
    lk_vld[3] = clr_valid && clr_s1;
    lk_val[3] = busy_all[clr_float ? IF1 : IG1];
    stall_base = group_start ? '0 : stall_q;
  end

  spr_stall_merge #(.N(NLK)) u_merge (
    .base(stall_base), .vld(lk_vld), .val(lk_val), .result(stall_d)
  );

  always_ff @(posedge clk) begin
    if (rst) stall_q <= '0;
    else     stall_q <= stall_d;
  end

  assign stall = stall_q;
endmodule

// File: rtl/spr_latency_board_chk.sv
module spr_latency_board_chk #(
  parameter int IDX_W = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  group_start,
  input logic signed [IDX_W:0] lk0_idx,
  input logic signed [IDX_W:0] lk1_idx,
  input logic                  clr_valid,
  input logic [7:0]            stall
);
  logic no_lookup;
  assign no_lookup = lk0_idx[IDX_W] && lk1_idx[IDX_W] && !clr_valid;

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> stall == 8'd0);

  assert_stall_monotone_R6: assert property (@(posedge clk) disable iff (rst)
    !group_start |=> stall >= $past(stall));

  assert_group_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (group_start && no_lookup) |=> stall == 8'd0);

  assert_negative_lookup_R3: assert property (@(posedge clk) disable iff (rst)
    (!group_start && no_lookup) |=> $stable(stall));
endmodule

bind spr_latency_board spr_latency_board_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .group_start(group_start),
  .lk0_idx(lk0_idx), .lk1_idx(lk1_idx), .clr_valid(clr_valid), .stall(stall)
);

// File: tb/test_spr_latency_board.sv
`timescale 1ns/1ps
module test_spr_latency_board;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic signed [5:0] topup_idx = -6'sd1;
  logic [15:0]       topup_cycles = '0;
  logic              div_valid = 1'b0;
  logic signed [7:0] div_dst = '0;
  logic              commit = 1'b0;
  logic [7:0]        adv_cycles = '0;
  logic              group_start = 1'b0;
  logic signed [5:0] lk0_idx = -6'sd1;
  logic signed [5:0] lk1_idx = -6'sd1;
  logic              clr_valid = 1'b0;
  logic              clr_float = 1'b0;
  logic signed [7:0] clr_reg = '0;
  logic [7:0]        stall;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spr_latency_board i_spr_latency_board (
    .clk(clk), .rst(rst), .topup_idx(topup_idx), .topup_cycles(topup_cycles),
    .div_valid(div_valid), .div_dst(div_dst), .commit(commit),
    .adv_cycles(adv_cycles), .group_start(group_start),
    .lk0_idx(lk0_idx), .lk1_idx(lk1_idx), .clr_valid(clr_valid),
    .clr_float(clr_float), .clr_reg(clr_reg), .stall(stall)
  );

  typedef struct packed {
    logic [5:0] tidx;
    logic [8:0] tcyc;
    logic       cm;
    logic [7:0] adv;
    logic       grp;
    logic [5:0] lk;
    logic [7:0] exp;
  } vec_t;

  localparam logic [5:0] NO = 6'h3f;
  localparam int NV = 25;
  // Covers R2 R3 R4 R5 R6 R10
  localparam vec_t TBL [NV] = '{
    '{6'd3,  9'd10,  1'b0, 8'd0,   1'b1, NO,    8'd0},
    '{NO,    9'd0,   1'b0, 8'd0,   1'b0, 6'd3,  8'd0},
    '{6'd3,  9'd5,   1'b1, 8'd0,   1'b0, NO,    8'd0},
    '{NO,    9'd0,   1'b0, 8'd0,   1'b0, 6'd3,  8'd10},
    '{NO,    9'd0,   1'b0, 8'd4,   1'b0, 6'd3,  8'd10},
    '{NO,    9'd0,   1'b0, 8'd0,   1'b1, 6'd3,  8'd6},
    '{NO,    9'd0,   1'b1, 8'd0,   1'b1, NO,    8'd0},
    '{NO,    9'd0,   1'b0, 8'd0,   1'b1, 6'd3,  8'd5},
    '{6'd9,  9'd20,  1'b0, 8'd0,   1'b1, NO,    8'd0},
    '{6'd9,  9'd7,   1'b0, 8'd0,   1'b1, NO,    8'd0},
    '{NO,    9'd0,   1'b1, 8'd0,   1'b1, NO,    8'd0},
    '{NO,    9'd0,   1'b0, 8'd0,   1'b1, 6'd9,  8'd20},
    '{NO,    9'd0,   1'b0, 8'd0,   1'b1, 6'd3,  8'd5},
    '{NO,    9'd0,   1'b0, 8'd255, 1'b1, NO,    8'd0},
    '{NO,    9'd0,   1'b0, 8'd0,   1'b1, 6'd9,  8'd0},
    '{6'h3b, 9'd50,  1'b0, 8'd0,   1'b1, NO,    8'd0},
    '{NO,    9'd0,   1'b1, 8'd0,   1'b1, NO,    8'd0},
    '{NO,    9'd0,   1'b0, 8'd0,   1'b1, 6'h3b, 8'd0},
    '{NO,    9'd0,   1'b0, 8'd0,   1'b1, 6'd27, 8'd0},
    '{6'd2,  9'd300, 1'b0, 8'd0,   1'b1, NO,    8'd0},
    '{NO,    9'd0,   1'b1, 8'd0,   1'b1, NO,    8'd0},
    '{NO,    9'd0,   1'b0, 8'd0,   1'b1, 6'd2,  8'd255},
    '{NO,    9'd0,   1'b0, 8'd250, 1'b1, NO,    8'd0},
    '{NO,    9'd0,   1'b0, 8'd0,   1'b1, 6'd2,  8'd5},
    '{NO,    9'd0,   1'b0, 8'd0,   1'b0, NO,    8'd5}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: stall actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    topup_idx = -6'sd1; topup_cycles = '0; div_valid = 1'b0; div_dst = '0;
    commit = 1'b0; adv_cycles = '0; group_start = 1'b0;
    lk0_idx = -6'sd1; lk1_idx = -6'sd1; clr_valid = 1'b0; clr_float = 1'b0; clr_reg = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic look(input logic [5:0] a, input logic [5:0] b);
    group_start = 1'b1; lk0_idx = a; lk1_idx = b;
    tick();
  endtask

  task automatic clr(input logic fl, input logic [7:0] rn);
    group_start = 1'b1; clr_valid = 1'b1; clr_float = fl; clr_reg = rn;
    tick();
  endtask

  task automatic flush();
    group_start = 1'b1; adv_cycles = 8'd255;
    tick();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_up();
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    chk("R1 reset state", stall, 8'd0);

    for (int i = 0; i < NV; i++) begin
      topup_idx = TBL[i].tidx; topup_cycles = 16'(TBL[i].tcyc);
      commit = TBL[i].cm; adv_cycles = TBL[i].adv; group_start = TBL[i].grp;
      lk0_idx = TBL[i].lk;
      tick();
      chk($sformatf("R2/R3/R4/R5/R6/R10 table row %0d", i), stall, TBL[i].exp);
    end

    // R9 R7: divide destination 40 -> general flag 0 (index 4)
    flush();
    div_valid = 1'b1; div_dst = 8'sd40; tick();
    commit = 1'b1; tick();
    look(6'd4, 6'd5); chk("R9 divide dst 40 flag0", stall, 8'd18);
    look(6'd5, NO);   chk("R7 dst 40 leaves flag1", stall, 8'd0);

    // R9 R7: destination 5 -> general flag 1 (index 5)
    flush();
    div_valid = 1'b1; div_dst = 8'sd5; tick();
    commit = 1'b1; tick();
    look(6'd5, NO); chk("R9 divide dst 5 flag1", stall, 8'd18);
    look(6'd4, NO); chk("R7 dst 5 leaves flag0", stall, 8'd0);

    // R7: destinations 0 and 70 map to nothing
    flush();
    div_valid = 1'b1; div_dst = 8'sd0; tick();
    div_valid = 1'b1; div_dst = 8'sd70; tick();
    commit = 1'b1; tick();
    look(6'd4, 6'd5); chk("R7 dst 0 and 70 unmapped", stall, 8'd0);

    // R8 R7: floating flags 6 and 7
    topup_idx = 6'sd6; topup_cycles = 16'd30; tick();
    topup_idx = 6'sd7; topup_cycles = 16'd12; tick();
    commit = 1'b1; tick();
    clr(1'b1, 8'hff);  chk("R8 clear-all float waits both", stall, 8'd30);
    clr(1'b1, 8'd10);  chk("R7 clear float reg 10", stall, 8'd12);
    clr(1'b1, 8'd40);  chk("R7 clear float reg 40", stall, 8'd30);
    clr(1'b1, 8'd0);   chk("R7 clear float reg 0", stall, 8'd0);
    clr(1'b0, 8'hff);  chk("R8 clear-all general class", stall, 8'd0);
    look(6'd7, 6'd6);  chk("R6 two lookup ports max", stall, 8'd30);

    // R1: reset clears live counts and staged values
    topup_idx = 6'sd7; topup_cycles = 16'd40; tick();
    rst = 1'b1; tick();
    rst = 1'b0;
    chk("R1 stall after reset", stall, 8'd0);
    commit = 1'b1; tick();
    look(6'd6, 6'd7); chk("R1 counts and staged cleared", stall, 8'd0);

    finish_up();
  end
endmodule